// File: doc/BRIEF.md
# Bit-Oriented Frame Transmitter with Automatic Frame Close

This block turns octets handed over through a one-octet holding buffer into a continuous bit-oriented (SDLC/HDLC style) serial stream, one line bit per clock. While nothing is queued it keeps sending opening/closing flags. Once an octet is written, a frame begins at the next octet boundary. Octets go out least significant bit first, and a zero is stuffed after any run of five ones so that the payload can never imitate a flag.

A DMA engine or a CPU keeps the frame going by answering a request line that is high whenever the holding buffer is empty. When the buffer runs dry in the middle of a frame, an underrun latch decides how the frame ends. If the latch has been cleared by a host command, the block appends the inverted 16-bit frame check sequence and a closing flag, then sets the latch. If the latch is already set, the frame is simply dropped back to flags with no check sequence. A select input chooses whether a host write or read addresses the command/status register or the data buffer.

Top module: `sdlc_tx_top`

## Requirements
- R1: With no octet pending, the line carries back-to-back flags of value 0x7E, bit 0 first.
- R2: An octet written to the data buffer (host_sel=1) while flags are being sent opens a frame at the next octet boundary. Frame octets are sent bit 0 first. Octets written while the frame runs follow with no gap.
- R3: Outside flags, a 0 is inserted on the line after every five consecutive 1s, and this includes the check-sequence octets. No zero is ever inserted inside a flag.
- R4: Status read (host_sel=0) bit 2 is 1 exactly when the data buffer is empty. tx_req follows the same condition. A data write clears both in the next cycle.
- R5: A command write (host_sel=0) whose bits [7:6] are 2'b11, such as 0xC0, clears the underrun latch. Any other command value leaves the latch unchanged. Status bit 6 shows the latch.
- R6: If the buffer is empty at an octet boundary inside a frame and the latch is clear, the block sends the 16-bit check sequence and then a flag, and it sets the latch. The check sequence uses x^16+x^12+x^5+1, is preset to all ones at frame start, and is computed over the frame bits in line order. It is sent inverted, high bit first.
- R7: If the buffer is empty at an octet boundary inside a frame and the latch is set, the frame ends with a flag and no check sequence.
- R8: After reset the buffer is empty, the latch is set, and a read with host_sel=1 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one line bit per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_sel | input | 1 | 0 = command/status, 1 = data buffer |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Status when host_sel=0 (bit 2 buffer empty, bit 6 latch), 0 otherwise |
| tx_req | output | 1 | Request for the next octet (buffer empty) |
| tx_sd | output | 1 | Serial line output |

## Verification
The bench decodes the line the way a receiver would. It strips stuffed zeros, finds flags and compares every recovered frame with the expected octets. A design that fails to stuff shows up as a spurious flag or abort in the middle of an all-ones payload. A design that stuffs inside flags breaks the flag hunt altogether. Frames close with and without the latch armed: a wrong check polynomial, preset, bit order or missing inversion changes the two trailing octets, and a latch that fails to set on underrun makes the following unarmed frame grow a check sequence. Commands with only bit 7 set probe whether the latch decode looks at both top bits.

// File: rtl/sdlc_tx_pkg.sv
package sdlc_tx_pkg;
    typedef enum logic [1:0] {
        K_FLAG   = 2'd0,
        K_DATA   = 2'd1,
        K_CRC_HI = 2'd2,
        K_CRC_LO = 2'd3
    } octet_kind_e;

    function automatic logic [7:0] bitrev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction
endpackage

// File: rtl/sdlc_crc_step.sv
module sdlc_crc_step #(
    parameter int          CRC_W    = 16,
    parameter logic [15:0] CRC_POLY = 16'h1021
) (
    input  logic [CRC_W-1:0] crc_in,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_out
);
    logic fb;
    always_comb begin
        fb      = crc_in[CRC_W-1] ^ bit_in;
        crc_out = {crc_in[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY[CRC_W-1:0] : '0);
    end
endmodule

// File: rtl/sdlc_tx_hostregs.sv
module sdlc_tx_hostregs #(
    parameter int OCTET_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               wr,
    input  logic [OCTET_W-1:0] wdata,
    input  logic               take,
    input  logic               latch_set,
    output logic [OCTET_W-1:0] buf_data,
    output logic               buf_full,
    output logic               urun_latch,
    output logic [OCTET_W-1:0] rdata
);
    typedef struct packed {
        logic [OCTET_W-1:0] data;
        logic               full;
        logic               latch;
    } hreg_t;

    hreg_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take)      h_d.full  = 1'b0;
        if (latch_set) h_d.latch = 1'b1;
        if (wr && sel) begin
            h_d.data = wdata;
            h_d.full = 1'b1;
        end
        if (wr && !sel && (wdata[7:6] == 2'b11)) h_d.latch = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q.data  <= '0;
            h_q.full  <= 1'b0;
            h_q.latch <= 1'b1;
        end else begin
            h_q <= h_d;
        end
    end

    always_comb begin
        rdata    = '0;
        if (!sel) begin
            rdata[2] = !h_q.full;
            rdata[6] = h_q.latch;
        end
        buf_data   = h_q.data;
        buf_full   = h_q.full;
        urun_latch = h_q.latch;
    end
endmodule

// File: rtl/sdlc_tx_top.sv
module sdlc_tx_top #(
    parameter logic [7:0]  FLAG_OCTET = 8'h7E,
    parameter int          STUFF_RUN  = 5,
    parameter int          CRC_W      = 16,
    parameter logic [15:0] CRC_POLY   = 16'h1021
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_sel,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       tx_req,
    output logic       tx_sd
);
    import sdlc_tx_pkg::*;

    localparam int OCTET_W = 8;
    localparam int CNT_W   = $clog2(OCTET_W);
    localparam int ONES_W  = $clog2(STUFF_RUN + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(OCTET_W - 1);
    localparam logic [ONES_W-1:0] RUN_MAX  = ONES_W'(STUFF_RUN);

    typedef struct packed {
        octet_kind_e        kind;
        logic [OCTET_W-1:0] sh;
        logic [CNT_W-1:0]   cnt;
        logic [ONES_W-1:0]  ones;
        logic [CRC_W-1:0]   crc;
    } ser_t;

    ser_t s_d, s_q;

    logic [OCTET_W-1:0] buf_data;
    logic               buf_full, urun_latch, take, latch_set;
    logic [CRC_W-1:0]   crc_stepped;
    logic               stuff_now, cur_bit;

    sdlc_tx_hostregs #(.OCTET_W(OCTET_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (host_sel),
        .wr         (host_wr),
        .wdata      (host_wdata),
        .take       (take),
        .latch_set  (latch_set),
        .buf_data   (buf_data),
        .buf_full   (buf_full),
        .urun_latch (urun_latch),
        .rdata      (host_rdata)
    );

    sdlc_crc_step #(.CRC_W(CRC_W), .CRC_POLY(CRC_POLY)) u_crc (
        .crc_in  (s_q.crc),
        .bit_in  (s_q.sh[0]),
        .crc_out (crc_stepped)
    );

    always_comb begin
        s_d       = s_q;
        take      = 1'b0;
        latch_set = 1'b0;
        stuff_now = (s_q.ones == RUN_MAX);
        cur_bit   = s_q.sh[0];

        if (stuff_now) begin
            s_d.ones = '0;
        end else begin
            if (s_q.kind == K_FLAG) s_d.ones = '0;
            else                    s_d.ones = cur_bit ? s_q.ones + 1'b1 : '0;
            if (s_q.kind == K_DATA) s_d.crc = crc_stepped;

            if (s_q.cnt == LAST_BIT) begin
                s_d.cnt = '0;
                unique case (s_q.kind)
                    K_FLAG: begin
                        if (buf_full) begin
                            s_d.kind = K_DATA;
                            s_d.sh   = buf_data;
                            s_d.crc  = '1;
                            take     = 1'b1;
                        end else begin
                            s_d.sh = FLAG_OCTET;
                        end
                    end
                    K_DATA: begin
                        if (buf_full) begin
                            s_d.sh = buf_data;
                            take   = 1'b1;
                        end else if (!urun_latch) begin
                            s_d.kind  = K_CRC_HI;
                            s_d.sh    = bitrev8(~crc_stepped[CRC_W-1 -: 8]);
                            latch_set = 1'b1;
                        end else begin
                            s_d.kind = K_FLAG;
                            s_d.sh   = FLAG_OCTET;
                        end
                    end
                    K_CRC_HI: begin
                        s_d.kind = K_CRC_LO;
                        s_d.sh   = bitrev8(~s_q.crc[7:0]);
                    end
                    default: begin
                        s_d.kind = K_FLAG;
                        s_d.sh   = FLAG_OCTET;
                    end
                endcase
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
                s_d.sh  = s_q.sh >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.kind <= K_FLAG;
            s_q.sh   <= FLAG_OCTET;
            s_q.cnt  <= '0;
            s_q.ones <= '0;
            s_q.crc  <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_sd  = stuff_now ? 1'b0 : cur_bit;
    assign tx_req = !buf_full;

    logic [ONES_W-1:0]  mon_ones;
    logic [OCTET_W-1:0] mon_sh;
    logic [1:0]         mon_kind;
    assign mon_ones = s_q.ones;
    assign mon_sh   = s_q.sh;
    assign mon_kind = s_q.kind;
endmodule

// File: rtl/sdlc_tx_checker.sv
module sdlc_tx_checker #(
    parameter int ONES_W    = 3,
    parameter int STUFF_RUN = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_sel,
    input logic              host_wr,
    input logic [7:0]        host_wdata,
    input logic [7:0]        host_rdata,
    input logic              tx_req,
    input logic              tx_sd,
    input logic [ONES_W-1:0] ones,
    input logic [7:0]        shreg,
    input logic [1:0]        kind,
    input logic              latch
);
    a_r3_run_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ones) <= STUFF_RUN);

    a_r3_stuff_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ones) == STUFF_RUN) |-> !tx_sd);

    a_r3_stuff_holds_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ones) == STUFF_RUN) |=> (ones == '0) && $stable(shreg));

    a_r4_write_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel) |=> !tx_req);

    a_r4_status_tracks_req: assert property (@(posedge clk) disable iff (!rst_n)
        !host_sel |-> (host_rdata[2] == tx_req));

    a_r5_cmd_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !host_sel && host_wdata[7:6] == 2'b11) |=> !latch);

    a_r6_latch_sets_on_crc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch) |-> (kind == 2'd2));
endmodule

bind sdlc_tx_top sdlc_tx_checker #(.ONES_W(ONES_W), .STUFF_RUN(STUFF_RUN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .tx_req     (tx_req),
    .tx_sd      (tx_sd),
    .ones       (mon_ones),
    .shreg      (mon_sh),
    .kind       (mon_kind),
    .latch      (urun_latch)
);

// File: tb/tb_sdlc_tx_top.sv
module tb_sdlc_tx_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_req, tx_sd;

    sdlc_tx_top dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tx_req(tx_req), .tx_sd(tx_sd)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int frames_done = 0;
    int flags_seen = 0;
    bit done = 1'b0;

    byte unsigned exp_bytes[$];
    int           exp_len[$];
    string        exp_tag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic byte unsigned rev8(input byte unsigned v);
        byte unsigned r = 0;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // scoreboard monitor: receiver-style decode of the line
    bit rx_bits[$];
    int ones_run = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit b;
            b = tx_sd;
            if (ones_run == 5 && b == 1'b0) begin
                ones_run = 0;
            end else if (ones_run == 6 && b == 1'b0) begin
                ones_run = 0;
                flags_seen++;
                for (int k = 0; k < 7 && rx_bits.size() > 0; k++) void'(rx_bits.pop_back());
                if (rx_bits.size() > 0) begin
                    int n;
                    n = rx_bits.size();
                    if (exp_len.size() == 0) begin
                        check(1'b0, "R2 unexpected frame", n, 0);
                    end else begin
                        int el;
                        string tg;
                        bit ok;
                        el = exp_len.pop_front();
                        tg = exp_tag.pop_front();
                        ok = (n == el * 8);
                        for (int o = 0; o < el; o++) begin
                            byte unsigned got, want;
                            got = 0;
                            want = exp_bytes.pop_front();
                            if (ok) for (int i = 0; i < 8; i++) got[i] = rx_bits[o*8+i];
                            if (got != want) begin
                                ok = 1'b0;
                                $display("  octet %0d got 0x%02h want 0x%02h", o, got, want);
                            end
                        end
                        check(ok, tg, n, el * 8);
                    end
                    frames_done++;
                end
                rx_bits.delete();
            end else if (ones_run == 6 && b == 1'b1) begin
                check(1'b0, "R3 seven ones on line", 7, 6);
                ones_run = 0;
                rx_bits.delete();
            end else begin
                rx_bits.push_back(b);
                ones_run = b ? ones_run + 1 : 0;
            end
        end
    end

    task automatic host_write(input bit sel, input byte unsigned v);
        host_sel   = sel;
        host_wr    = 1'b1;
        host_wdata = v;
        @(negedge clk);
        host_wr    = 1'b0;
        host_sel   = 1'b0;
    endtask

    // driver: pushes expected frame then feeds octets on request
    task automatic send_frame(input byte unsigned d[$], input bit armed, input string tag);
        int target;
        logic [15:0] crc;
        target = frames_done + 1;
        if (armed) host_write(1'b0, 8'hC0);
        crc = 16'hFFFF;
        foreach (d[j]) begin
            exp_bytes.push_back(d[j]);
            for (int i = 0; i < 8; i++) begin
                bit fb;
                fb  = crc[15] ^ d[j][i];
                crc = {crc[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
            end
        end
        if (armed) begin
            exp_bytes.push_back(rev8(~crc[15:8]));
            exp_bytes.push_back(rev8(~crc[7:0]));
        end
        exp_len.push_back(d.size() + (armed ? 2 : 0));
        exp_tag.push_back(tag);
        foreach (d[j]) begin
            while (!tx_req) @(negedge clk);
            host_write(1'b1, d[j]);
            if (j == 0) begin
                check(!tx_req && host_rdata[2] == 1'b0, "R4 data write clears empty",
                      {tx_req, host_rdata[2]}, 0);
            end
        end
        while (frames_done < target) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        check(1'b0, "watchdog", cyc, 0);
        finish_run();
    end

    initial begin
        byte unsigned f[$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check(tx_req == 1'b1, "R8 reset buffer empty", tx_req, 1);
        check(host_rdata[6] == 1'b1, "R8 reset latch set", host_rdata[6], 1);
        check(host_rdata[2] == 1'b1, "R4 status empty bit", host_rdata[2], 1);
        host_sel = 1'b1;
        #0.1;
        check(host_rdata == 8'h00, "R8 data-select read zero", host_rdata, 0);
        host_sel = 1'b0;
        // R1 idle flags only
        repeat (40) @(negedge clk);
        check(flags_seen >= 4 && frames_done == 0, "R1 idle flags", flags_seen, 4);
        // R5 command decode
        host_write(1'b0, 8'h80);
        check(host_rdata[6] == 1'b1, "R5 other command ignored", host_rdata[6], 1);
        host_write(1'b0, 8'hC0);
        check(host_rdata[6] == 1'b0, "R5 command clears latch", host_rdata[6], 0);
        // R6 single octet, armed
        f = '{8'hA5};
        send_frame(f, 1'b1, "R6 crc close single octet");
        check(host_rdata[6] == 1'b1, "R6 latch set after close", host_rdata[6], 1);
        // R3 stuffing-heavy payload
        f = '{8'hFF, 8'hFF, 8'h7E, 8'h3F, 8'hF8};
        send_frame(f, 1'b1, "R3 stuffed payload with crc");
        // R7 latch set: no crc
        f = '{8'h12, 8'h34};
        send_frame(f, 1'b0, "R7 underrun without crc");
        check(host_rdata[6] == 1'b1, "R7 latch stays set", host_rdata[6], 1);
        // R2 multi-octet ordering
        f = '{8'h00, 8'h01, 8'h80, 8'hC3};
        send_frame(f, 1'b1, "R2 octet order and crc");
        repeat (30) @(negedge clk);
        check(frames_done == 4 && exp_len.size() == 0, "R1 flags after last frame",
              frames_done, 4);
        check(tx_req == 1'b1, "R4 empty after frames", tx_req, 1);
        finish_run();
    end
endmodule